// File: doc/BRIEF.md
# Protection and Trap Flag Unit

This block raises the three protection and timing trap flags of a small accumulator CPU. The first is the memory-protection flag. While the CPU runs in user mode, a fence comparator checks every address placed in the memory address register against a boundary register. Any address strictly below the boundary belongs to the resident handler. An access to such an address blocks the memory transfer and sets the flag. The second is the privilege flag. It is raised when the instruction register holds an opcode above the last opcode open to user code while the mode bit is 0.

A down-counting watchdog timer is the third source. Supervisor code loads it with a count. It decrements on each tick-enable cycle and raises the timer flag when it reaches zero. A count of zero leaves the timer idle.

All three flags are sticky. They hold until the interrupt controller sends a one-cycle clear. A memory-access inhibit output lets the CPU skip the memory step of a load, add or store. It acts in the same cycle as the offending address and stays high for as long as the protection flag is set. Supervisor mode (mode bit 1) bypasses both checks. It is also the only mode in which the fence and the timer can be written.

Top module: `prot_trap_unit`

## Requirements
- R1: After a synchronous reset, all three flags and the inhibit output are 0, the fence holds FENCE_RST (0 by default) and the timer is idle at zero.
- R2: A cycle with mar_load high, mode 0 and mar_addr strictly below the fence sets mp_flag at the next clock edge. An address equal to or above the fence does not set it.
- R3: mem_inhibit is 1 in the same cycle as a violating mar_load, with no register on the path. It also stays 1 in every cycle in which mp_flag is 1.
- R4: With mode 1, no address sets mp_flag or mem_inhibit and no opcode sets pi_flag.
- R5: With mode 0, an ir_op greater than LAST_USER_OP (59 by default) sets pi_flag at the next edge. ir_op equal to LAST_USER_OP does not set it.
- R6: After the timer is loaded with N > 0, ti_flag rises at the edge of the N-th following tick_en cycle and not before.
- R7: With the timer at zero, tick_en does not decrement it and does not set ti_flag.
- R8: Each flag stays set until its clear input is high for a cycle. The flag then reads 0 after that edge.
- R9: When a clear and a new set condition for the same flag occur in the same cycle, the flag stays 1.
- R10: fence_we and timer_we are ignored when mode is 0. The fence and the timer keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mar_addr | input | ADDR_W | Address held in the memory address register |
| mar_load | input | 1 | High in the cycle the memory address register is loaded for a data access |
| ir_op | input | OP_W | Opcode field of the instruction register |
| mode | input | 1 | 1 = supervisor, 0 = user |
| tick_en | input | 1 | Timer decrement enable |
| fence_we | input | 1 | Fence write strobe (supervisor only) |
| fence_din | input | ADDR_W | New fence value |
| timer_we | input | 1 | Timer write strobe (supervisor only) |
| timer_din | input | TIMER_W | New timer count |
| clr_mp | input | 1 | Clear pulse for the protection flag |
| clr_pi | input | 1 | Clear pulse for the privilege flag |
| clr_ti | input | 1 | Clear pulse for the timer flag |
| mp_flag | output | 1 | Sticky memory-protection violation flag |
| pi_flag | output | 1 | Sticky privileged-opcode flag |
| ti_flag | output | 1 | Sticky timer-expired flag |
| mem_inhibit | output | 1 | Blocks the memory transfer |

## Verification
The bench uses ADDR_W 12, OP_W 7, TIMER_W 16 and LAST_USER_OP 59, and loads a fence of 4000. These settings place the fence boundary (3999 against 4000), the top of the address space (4095) and the opcode threshold (59 against 60, up to 127) all within the stimulus table. The timer is loaded with small counts, so expiry, the idle state at zero and ignored user-mode loads each take only a handful of ticks.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int NUM_FLAGS = 3;
  localparam int IDX_MP    = 0;
  localparam int IDX_PI    = 1;
  localparam int IDX_TI    = 2;
endpackage

// File: rtl/fence_guard.sv
module fence_guard #(
  parameter int ADDR_W    = 12,
  parameter int FENCE_RST = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic              fence_we,
  input  logic [ADDR_W-1:0] fence_din,
  input  logic              mar_load,
  input  logic [ADDR_W-1:0] mar_addr,
  output logic              violation
);
  localparam logic [ADDR_W-1:0] RST_VAL = ADDR_W'(FENCE_RST);

  logic [ADDR_W-1:0] fence_q;

  always_ff @(posedge clk) begin
    if (rst)
      fence_q <= RST_VAL;
    else if (fence_we && mode)
      fence_q <= fence_din;
  end

  always_comb begin
    violation = mar_load && !mode && (mar_addr < fence_q);
  end
endmodule

// File: rtl/trap_timer.sv
module trap_timer #(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode,
  input  logic               timer_we,
  input  logic [TIMER_W-1:0] timer_din,
  input  logic               tick_en,
  output logic               expire
);
  localparam logic [TIMER_W-1:0] ONE = TIMER_W'(1);

  logic [TIMER_W-1:0] cnt_q;
  logic               running;

  always_comb begin
    running = (cnt_q != '0);
    expire  = tick_en && (cnt_q == ONE) && !(timer_we && mode);
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (timer_we && mode)
      cnt_q <= timer_din;
    else if (tick_en && running)
      cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flag_o[g] <= 1'b0;
      else if (set_i[g])
        flag_o[g] <= 1'b1;
      else if (clr_i[g])
        flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/prot_trap_unit.sv
module prot_trap_unit
  import prot_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int OP_W         = 7,
  parameter int TIMER_W      = 16,
  parameter int LAST_USER_OP = 59,
  parameter int FENCE_RST    = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  mar_addr,
  input  logic               mar_load,
  input  logic [OP_W-1:0]    ir_op,
  input  logic               mode,
  input  logic               tick_en,
  input  logic               fence_we,
  input  logic [ADDR_W-1:0]  fence_din,
  input  logic               timer_we,
  input  logic [TIMER_W-1:0] timer_din,
  input  logic               clr_mp,
  input  logic               clr_pi,
  input  logic               clr_ti,
  output logic               mp_flag,
  output logic               pi_flag,
  output logic               ti_flag,
  output logic               mem_inhibit
);
  localparam logic [OP_W-1:0] OP_LIMIT = OP_W'(LAST_USER_OP);

  logic                 addr_bad;
  logic                 op_bad;
  logic                 tmr_expire;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] clr_vec;
  logic [NUM_FLAGS-1:0] flag_vec;

  fence_guard #(.ADDR_W(ADDR_W), .FENCE_RST(FENCE_RST)) u_fence (
    .clk(clk), .rst(rst), .mode(mode),
    .fence_we(fence_we), .fence_din(fence_din),
    .mar_load(mar_load), .mar_addr(mar_addr),
    .violation(addr_bad)
  );

  trap_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk(clk), .rst(rst), .mode(mode),
    .timer_we(timer_we), .timer_din(timer_din),
    .tick_en(tick_en), .expire(tmr_expire)
  );

  always_comb begin
    op_bad           = !mode && (ir_op > OP_LIMIT);
    set_vec          = '0;
    set_vec[IDX_MP]  = addr_bad;
    set_vec[IDX_PI]  = op_bad;
    set_vec[IDX_TI]  = tmr_expire;
    clr_vec          = '0;
    clr_vec[IDX_MP]  = clr_mp;
    clr_vec[IDX_PI]  = clr_pi;
    clr_vec[IDX_TI]  = clr_ti;
  end

  sticky_flags #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(clr_vec), .flag_o(flag_vec)
  );

  always_comb begin
    mp_flag     = flag_vec[IDX_MP];
    pi_flag     = flag_vec[IDX_PI];
    ti_flag     = flag_vec[IDX_TI];
    mem_inhibit = addr_bad || flag_vec[IDX_MP];
  end
endmodule

// File: rtl/prot_trap_unit_chk.sv
module prot_trap_unit_chk #(
  parameter int ADDR_W       = 12,
  parameter int OP_W         = 7,
  parameter int LAST_USER_OP = 59
) (
  input logic            clk,
  input logic            rst,
  input logic            mar_load,
  input logic [OP_W-1:0] ir_op,
  input logic            mode,
  input logic            clr_mp,
  input logic            clr_pi,
  input logic            clr_ti,
  input logic            mp_flag,
  input logic            pi_flag,
  input logic            ti_flag,
  input logic            mem_inhibit
);
  localparam logic [OP_W-1:0] LIM = OP_W'(LAST_USER_OP);

  // R2
  mp_set_chk: assert property (@(posedge clk) disable iff (rst)
    (mar_load && !mode && mem_inhibit && !mp_flag) |=> mp_flag);

  // R3
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mp_flag |-> mem_inhibit);

  // R4
  super_free_chk: assert property (@(posedge clk) disable iff (rst)
    (mode && !mp_flag) |-> !mem_inhibit);

  // R5
  pi_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode && ir_op > LIM) |=> pi_flag);

  // R8
  mp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (mp_flag && !clr_mp) |=> mp_flag);

  // R8
  ti_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ti_flag && !clr_ti) |=> ti_flag);

  // R8
  pi_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_pi && (mode || ir_op <= LIM)) |=> !pi_flag);
endmodule

bind prot_trap_unit prot_trap_unit_chk #(
  .ADDR_W(ADDR_W), .OP_W(OP_W), .LAST_USER_OP(LAST_USER_OP)
) u_chk (
  .clk(clk), .rst(rst), .mar_load(mar_load), .ir_op(ir_op), .mode(mode),
  .clr_mp(clr_mp), .clr_pi(clr_pi), .clr_ti(clr_ti),
  .mp_flag(mp_flag), .pi_flag(pi_flag), .ti_flag(ti_flag),
  .mem_inhibit(mem_inhibit)
);

// File: tb/prot_trap_unit_test.sv
module prot_trap_unit_test;
  localparam int AW = 12;
  localparam int OW = 7;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mar_addr = '0;
  logic          mar_load = 1'b0;
  logic [OW-1:0] ir_op = '0;
  logic          mode = 1'b1;
  logic          tick_en = 1'b0;
  logic          fence_we = 1'b0;
  logic [AW-1:0] fence_din = '0;
  logic          timer_we = 1'b0;
  logic [TW-1:0] timer_din = '0;
  logic          clr_mp = 1'b0, clr_pi = 1'b0, clr_ti = 1'b0;
  logic          mp_flag, pi_flag, ti_flag, mem_inhibit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  prot_trap_unit #(.ADDR_W(AW), .OP_W(OW), .TIMER_W(TW), .LAST_USER_OP(59)) uut (
    .clk(clk), .rst(rst), .mar_addr(mar_addr), .mar_load(mar_load),
    .ir_op(ir_op), .mode(mode), .tick_en(tick_en),
    .fence_we(fence_we), .fence_din(fence_din),
    .timer_we(timer_we), .timer_din(timer_din),
    .clr_mp(clr_mp), .clr_pi(clr_pi), .clr_ti(clr_ti),
    .mp_flag(mp_flag), .pi_flag(pi_flag), .ti_flag(ti_flag),
    .mem_inhibit(mem_inhibit)
  );

  // {mode, addr[11:0], op[6:0], exp_inhibit, exp_mp, exp_pi}; fence = 4000
  localparam logic [22:0] VEC [8] = '{
    {1'b0, 12'd3999, 7'd1,   1'b1, 1'b1, 1'b0},  // R2 R3 just below fence
    {1'b0, 12'd4000, 7'd2,   1'b0, 1'b0, 1'b0},  // R2 equal to fence
    {1'b0, 12'd0,    7'd3,   1'b1, 1'b1, 1'b0},  // R2 lowest address
    {1'b1, 12'd100,  7'd80,  1'b0, 1'b0, 1'b0},  // R4 supervisor
    {1'b0, 12'd4095, 7'd60,  1'b0, 1'b0, 1'b1},  // R5 first privileged opcode
    {1'b0, 12'd4001, 7'd59,  1'b0, 1'b0, 1'b0},  // R5 last user opcode
    {1'b0, 12'd3500, 7'd127, 1'b1, 1'b1, 1'b1},  // R2 R5 both at once
    {1'b1, 12'd3999, 7'd59,  1'b0, 1'b0, 1'b0}   // R4 supervisor below fence
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    mar_load = 1'b0; fence_we = 1'b0; timer_we = 1'b0;
    clr_mp = 1'b0; clr_pi = 1'b0; clr_ti = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    mar_load = 1'b0; ir_op = '0; mode = 1'b1;
    clr_mp = 1'b1; clr_pi = 1'b1; clr_ti = 1'b1;
    idle_cycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 mp after reset", mp_flag, 0);
    chk("R1 pi after reset", pi_flag, 0);
    chk("R1 ti after reset", ti_flag, 0);
    chk("R1 inhibit after reset", mem_inhibit, 0);

    // supervisor loads fence 4000
    @(negedge clk);
    mode = 1'b1; fence_we = 1'b1; fence_din = 12'd4000;
    idle_cycle();

    foreach (VEC[i]) begin
      clear_all();
      mode = VEC[i][22]; mar_addr = VEC[i][21:10]; ir_op = VEC[i][9:3];
      mar_load = 1'b1;
      #1;
      chk($sformatf("R3 vec%0d inhibit same cycle", i), mem_inhibit, VEC[i][2]);
      @(negedge clk);
      mar_load = 1'b0; ir_op = '0; mode = 1'b1;
      #1;
      chk($sformatf("R2 vec%0d mp", i), mp_flag, VEC[i][1]);
      chk($sformatf("R5 vec%0d pi", i), pi_flag, VEC[i][0]);
      chk($sformatf("R3 vec%0d inhibit held", i), mem_inhibit, VEC[i][1]);
    end

    // R8: clear of mp
    clear_all();
    @(negedge clk);
    mode = 1'b0; mar_addr = 12'd5; mar_load = 1'b1;
    @(negedge clk);
    mar_load = 1'b0; mode = 1'b1;
    repeat (2) @(negedge clk);
    #1 chk("R8 mp sticky", mp_flag, 1);
    @(negedge clk);
    clr_mp = 1'b1;
    idle_cycle();
    #1;
    chk("R8 mp cleared", mp_flag, 0);
    chk("R8 inhibit released", mem_inhibit, 0);

    // R9: clear and set same cycle for pi
    @(negedge clk);
    mode = 1'b0; ir_op = 7'd100;
    @(negedge clk);
    clr_pi = 1'b1;
    @(negedge clk);
    #1 chk("R9 pi set wins over clear", pi_flag, 1);
    ir_op = '0; mode = 1'b1;
    idle_cycle();
    #1 chk("R8 pi cleared", pi_flag, 0);

    // R6: timer load 3, expires on third tick
    clear_all();
    @(negedge clk);
    mode = 1'b1; timer_we = 1'b1; timer_din = 16'd3;
    @(negedge clk);
    timer_we = 1'b0; mode = 1'b0; tick_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1 chk("R6 ti not yet after 2 ticks", ti_flag, 0);
    @(negedge clk);
    #1 chk("R6 ti after 3 ticks", ti_flag, 1);
    repeat (3) @(negedge clk);
    #1 chk("R8 ti sticky", ti_flag, 1);
    clr_ti = 1'b1;
    idle_cycle();
    repeat (4) @(negedge clk);
    #1 chk("R7 idle timer no ti", ti_flag, 0);

    // R10: user-mode timer and fence writes ignored
    @(negedge clk);
    mode = 1'b0; timer_we = 1'b1; timer_din = 16'd2;
    fence_we = 1'b1; fence_din = 12'd0;
    idle_cycle();
    repeat (5) @(negedge clk);
    #1 chk("R10 user timer load ignored", ti_flag, 0);
    tick_en = 1'b0;
    mar_addr = 12'd10; mar_load = 1'b1;
    #1 chk("R10 user fence write ignored", mem_inhibit, 1);
    clear_all();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule